// File: doc/BRIEF.md
# Memory Bank Address Decoder

This block turns a physical address into a memory bank selection. It keeps a small set of logical bank decode registers, four by default, which software loads through a plain write port. Each register holds an enable flag and two key/compare pairs. One pair covers an upper slice of the address and the other covers a lower slice. A key bit set to 1 makes the matching address bit a "don't care". Every lookup tests all banks in parallel. The bank with the lowest index among those that match wins.

Lookups travel on a valid/ready stream. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its result appears on the response stream in the next cycle and stays there until `rsp_ready` is high at a clock edge. `req_ready` is high whenever the response register is empty, or whenever the held response is being taken in the same cycle. A stalled consumer therefore stops new lookups from entering without losing the result it is holding. The decoder also works out each bank's interleave factor, base address and size straight from the stored register. A side query port shows these values for any bank, with no clock delay.

Top module: `bank_addr_decoder`

## Requirements
- R1: A bank whose enable flag (register bit 63) is 0 never matches. Reset clears every enable flag, so no lookup hits until a bank has been written.
- R2: Upper slice rule. Address bits [41:30] are XORed with the low 12 bits of the compare field UM (register bits [40:20]). Every position where the key field UK (register bits [52:41]) is 1 is then cleared. The slice matches only if the result is zero. UM bits above bit 11 play no part in matching.
- R3: Lower slice rule. The same rule applies to address bits [9:6], with compare field LM (register bits [13:10]) and key field LK (register bits [17:14]).
- R4: A bank matches only if both of its slices match.
- R5: When more than one bank matches, the response names the lowest-indexed one.
- R6: The interleave factor comes from LK. 0xF gives 1, 0xE gives 2, 0xC gives 4, 0x8 gives 8 and 0x0 gives 16. Any other LK value gives 1.
- R7: Base address = (UM AND NOT UK, with UK zero-extended to the 21-bit UM width) shifted left by 30.
- R8: Size = ((UK[9:0] + 1) shifted left by 30) divided by the interleave factor. UK bits 11 and 10 do not affect size.
- R9: The response carries a global bank id equal to PORT_ID × NUM_BANKS + local index (default PORT_ID = 2, so ids 8 to 11).
- R10: A request accepted at a clock edge makes `rsp_valid` high in the following cycle, with the hit flag, index, interleave factor and global id. A miss reports index 0, interleave 0 and id 0.
- R11: `req_ready` = !rsp_valid || rsp_ready. While `rsp_valid` is high and `rsp_ready` is low, the response fields hold steady and no new request is taken.
- R12: A lookup accepted in the same cycle as a register write is decoded with the register contents from before that write. The write is seen from the next lookup onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for a decode register |
| cfg_wr_sel | input | 2 | Index of the register to write |
| cfg_wr_data | input | 64 | Register value |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_addr | input | 48 | Physical address to decode |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Some bank matched |
| rsp_bank | output | 2 | Index of the winning bank |
| rsp_ilv | output | 5 | Interleave factor of the winning bank |
| rsp_gid | output | 6 | Global bank id of the winning bank |
| info_sel | input | 2 | Bank picked for the query port |
| info_valid | output | 1 | Enable flag of the picked bank |
| info_ilv | output | 5 | Interleave factor of the picked bank |
| info_base | output | 64 | Base address of the picked bank |
| info_size | output | 64 | Size of the picked bank |

## Verification
Two pairs of events can happen in the same cycle. The first is a register write together with an accepted lookup that the write affects. The bench drives the strobe and the request on the same falling edge. It expects a miss from the old contents, then a hit on the next lookup. The second is a stalled response together with a pending request. The bench holds `rsp_ready` low with a second request already waiting. It checks that the first result stays in place and that `req_ready` stays low. It then releases the stall and expects the second result exactly one cycle later.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  localparam int UP_W   = 12;
  localparam int LO_W   = 4;
  localparam int UK_W   = 12;
  localparam int UM_W   = 21;
  localparam int LK_W   = 4;
  localparam int LM_W   = 4;
  localparam int EN_BIT = 63;
  localparam int UK_LSB = 41;
  localparam int UM_LSB = 20;
  localparam int LK_LSB = 14;
  localparam int LM_LSB = 10;
  localparam int SIZE_KEY_W = 10;

  typedef struct packed {
    logic            en;
    logic [UK_W-1:0] uk;
    logic [UM_W-1:0] um;
    logic [LK_W-1:0] lk;
    logic [LM_W-1:0] lm;
  } bank_cfg_t;

  function automatic bank_cfg_t unpack_cfg(input logic [63:0] w);
    bank_cfg_t c;
    c.en = w[EN_BIT];
    c.uk = w[UK_LSB +: UK_W];
    c.um = w[UM_LSB +: UM_W];
    c.lk = w[LK_LSB +: LK_W];
    c.lm = w[LM_LSB +: LM_W];
    return c;
  endfunction

  function automatic logic [2:0] ilv_shift(input logic [LK_W-1:0] lk);
    case (lk)
      4'hE:    return 3'd1;
      4'hC:    return 3'd2;
      4'h8:    return 3'd3;
      4'h0:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/mbd_bank.sv
module mbd_bank
  import mbd_pkg::*;
#(
  parameter int UP_LSB = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  bank_cfg_t       wr_cfg,
  input  logic [UP_W-1:0] addr_up,
  input  logic [LO_W-1:0] addr_lo,
  output logic            match,
  output logic            cfg_en,
  output logic [2:0]      shift,
  output logic [63:0]     base,
  output logic [63:0]     size
);
  bank_cfg_t cfg_q;
  logic up_ok, lo_ok;
  logic [UM_W-1:0] um_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else if (wr_en) cfg_q <= wr_cfg;
  end

  always_comb begin
    up_ok  = (((addr_up ^ cfg_q.um[UP_W-1:0]) & ~cfg_q.uk) == '0);
    lo_ok  = (((addr_lo ^ cfg_q.lm) & ~cfg_q.lk) == '0);
    match  = cfg_q.en & up_ok & lo_ok;
    cfg_en = cfg_q.en;
    shift  = ilv_shift(cfg_q.lk);
    um_clr = cfg_q.um & ~{{(UM_W-UK_W){1'b0}}, cfg_q.uk};
    base   = 64'(um_clr) << UP_LSB;
    size   = ((64'(cfg_q.uk[SIZE_KEY_W-1:0]) + 64'd1) << UP_LSB) >> shift;
  end
endmodule

// File: rtl/mbd_first_hit.sv
module mbd_first_hit #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  match,
  output logic          hit,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  grant
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
    grant = hit ? (N'(1) << idx) : '0;
  end

  assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_in_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~match) == '0);
endmodule

// File: rtl/bank_addr_decoder.sv
module bank_addr_decoder
  import mbd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int PA_W      = 48,
  parameter int UP_LSB    = 30,
  parameter int LO_LSB    = 6,
  parameter int PORT_W    = 4,
  parameter int PORT_ID   = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_wr_en,
  input  logic [$clog2(NUM_BANKS)-1:0]         cfg_wr_sel,
  input  logic [63:0]                          cfg_wr_data,
  input  logic                                 req_valid,
  output logic                                 req_ready,
  input  logic [PA_W-1:0]                      req_addr,
  output logic                                 rsp_valid,
  input  logic                                 rsp_ready,
  output logic                                 rsp_hit,
  output logic [$clog2(NUM_BANKS)-1:0]         rsp_bank,
  output logic [4:0]                           rsp_ilv,
  output logic [PORT_W+$clog2(NUM_BANKS)-1:0]  rsp_gid,
  input  logic [$clog2(NUM_BANKS)-1:0]         info_sel,
  output logic                                 info_valid,
  output logic [4:0]                           info_ilv,
  output logic [63:0]                          info_base,
  output logic [63:0]                          info_size
);
  localparam int IW = $clog2(NUM_BANKS);
  localparam int GW = PORT_W + IW;
  localparam logic [PA_W-1:0] USED_MASK =
    ({{(PA_W-UP_W){1'b0}}, {UP_W{1'b1}}} << UP_LSB) |
    ({{(PA_W-LO_W){1'b0}}, {LO_W{1'b1}}} << LO_LSB);

  bank_cfg_t wr_cfg;
  logic [UP_W-1:0] addr_up;
  logic [LO_W-1:0] addr_lo;
  logic [NUM_BANKS-1:0] match, en;
  logic [2:0]  shift [NUM_BANKS];
  logic [63:0] base  [NUM_BANKS];
  logic [63:0] size  [NUM_BANKS];
  logic          any_hit;
  logic [IW-1:0] win;
  logic [NUM_BANKS-1:0] grant;
  logic unused_bits;

  assign wr_cfg  = unpack_cfg(cfg_wr_data);
  assign addr_up = req_addr[UP_LSB +: UP_W];
  assign addr_lo = req_addr[LO_LSB +: LO_W];
  assign unused_bits = ^(req_addr & ~USED_MASK) ^ ^cfg_wr_data[62:53]
                     ^ ^cfg_wr_data[19:18] ^ ^cfg_wr_data[9:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    mbd_bank #(.UP_LSB(UP_LSB)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_wr_en && (cfg_wr_sel == IW'(b))),
      .wr_cfg (wr_cfg),
      .addr_up(addr_up),
      .addr_lo(addr_lo),
      .match  (match[b]),
      .cfg_en (en[b]),
      .shift  (shift[b]),
      .base   (base[b]),
      .size   (size[b])
    );
  end

  mbd_first_hit #(.N(NUM_BANKS)) u_pick (
    .clk  (clk),
    .rst_n(rst_n),
    .match(match),
    .hit  (any_hit),
    .idx  (win),
    .grant(grant)
  );

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_bank  <= '0;
      rsp_ilv   <= '0;
      rsp_gid   <= '0;
    end else if (req_valid && req_ready) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= any_hit;
      rsp_bank  <= any_hit ? win : '0;
      rsp_ilv   <= any_hit ? (5'd1 << shift[win]) : 5'd0;
      rsp_gid   <= any_hit ? GW'(PORT_ID * NUM_BANKS + int'(win)) : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign info_valid = en[info_sel];
  assign info_ilv   = 5'd1 << shift[info_sel];
  assign info_base  = base[info_sel];
  assign info_size  = size[info_sel];

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  assert_miss_fields_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_ilv == 5'd0 && rsp_bank == '0 && rsp_gid == '0));
  assert_ilv_pow2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> $onehot(rsp_ilv));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_bank)
                                   && $stable(rsp_ilv) && $stable(rsp_gid)));
endmodule

// File: tb/tb_bank_addr_decoder.sv
module tb_bank_addr_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr_en = 1'b0;
  logic [1:0] cfg_wr_sel = '0;
  logic [63:0] cfg_wr_data = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [47:0] req_addr = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic rsp_hit;
  logic [1:0] rsp_bank;
  logic [4:0] rsp_ilv;
  logic [5:0] rsp_gid;
  logic [1:0] info_sel = '0;
  logic info_valid;
  logic [4:0] info_ilv;
  logic [63:0] info_base, info_size;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_addr_decoder dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_bank(rsp_bank), .rsp_ilv(rsp_ilv), .rsp_gid(rsp_gid),
    .info_sel(info_sel), .info_valid(info_valid), .info_ilv(info_ilv),
    .info_base(info_base), .info_size(info_size)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] cfg_word(input logic en, input logic [11:0] uk,
      input logic [20:0] um, input logic [3:0] lk, input logic [3:0] lm);
    return {en, 10'b0, uk, um, 2'b0, lk, lm, 10'b0};
  endfunction

  function automatic logic [47:0] mk_addr(input logic [11:0] up, input logic [3:0] lo);
    return (48'(up) << 30) | (48'(lo) << 6) | 48'h25;
  endfunction

  task automatic wr_bank(input logic [1:0] sel, input logic [63:0] w);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = w;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic lookup(input logic [47:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string tag, input logic hit, input logic [1:0] bank,
      input logic [4:0] ilv, input logic [5:0] gid);
    chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " hit"},   64'(rsp_hit),   64'(hit));
    chk({tag, " bank"},  64'(rsp_bank),  64'(bank));
    chk({tag, " ilv"},   64'(rsp_ilv),   64'(ilv));
    chk({tag, " gid"},   64'(rsp_gid),   64'(gid));
  endtask

  task automatic t_reset;
    chk("R10 idle after reset", 64'(rsp_valid), 64'd0);
    chk("R11 ready after reset", 64'(req_ready), 64'd1);
    info_sel = 2'd0; #1;
    chk("R1 enable cleared", 64'(info_valid), 64'd0);
    lookup(mk_addr(12'h005, 4'h0));
    expect_rsp("R1 no hit after reset", 1'b0, 2'd0, 5'd0, 6'd0);
  endtask

  task automatic t_upper;
    wr_bank(2'd0, cfg_word(1'b1, 12'h000, 21'h100005, 4'hF, 4'h0));
    lookup(mk_addr(12'h005, 4'hA));
    expect_rsp("R2 upper exact match", 1'b1, 2'd0, 5'd1, 6'd8);
    lookup(mk_addr(12'h006, 4'hA));
    expect_rsp("R2 upper mismatch", 1'b0, 2'd0, 5'd0, 6'd0);
    wr_bank(2'd1, cfg_word(1'b1, 12'h003, 21'h000010, 4'hF, 4'h0));
    lookup(mk_addr(12'h013, 4'h0));
    expect_rsp("R2 key bits ignored", 1'b1, 2'd1, 5'd1, 6'd9);
    lookup(mk_addr(12'h014, 4'h0));
    expect_rsp("R2 unkeyed bit differs", 1'b0, 2'd0, 5'd0, 6'd0);
  endtask

  task automatic t_lower;
    wr_bank(2'd2, cfg_word(1'b1, 12'h000, 21'h000020, 4'hC, 4'h1));
    lookup(mk_addr(12'h020, 4'h5));
    expect_rsp("R3 lower match", 1'b1, 2'd2, 5'd4, 6'd10);
    lookup(mk_addr(12'h020, 4'h6));
    expect_rsp("R3 lower mismatch", 1'b0, 2'd0, 5'd0, 6'd0);
    lookup(mk_addr(12'h021, 4'h5));
    expect_rsp("R4 lower only is a miss", 1'b0, 2'd0, 5'd0, 6'd0);
  endtask

  task automatic t_priority;
    wr_bank(2'd3, cfg_word(1'b1, 12'hFFF, 21'h0, 4'hF, 4'h0));
    lookup(mk_addr(12'h005, 4'h0));
    expect_rsp("R5 lowest index wins", 1'b1, 2'd0, 5'd1, 6'd8);
    lookup(mk_addr(12'h7FF, 4'h3));
    expect_rsp("R5 catch-all bank", 1'b1, 2'd3, 5'd1, 6'd11);
    lookup(mk_addr(12'h020, 4'h6));
    expect_rsp("R5 falls through to bank 3", 1'b1, 2'd3, 5'd1, 6'd11);
  endtask

  task automatic t_invalid;
    wr_bank(2'd3, cfg_word(1'b0, 12'hFFF, 21'h0, 4'hF, 4'h0));
    lookup(mk_addr(12'h7FF, 4'h3));
    expect_rsp("R1 disabled bank ignored", 1'b0, 2'd0, 5'd0, 6'd0);
    info_sel = 2'd3; #1;
    chk("R1 info enable low", 64'(info_valid), 64'd0);
  endtask

  task automatic t_info;
    info_sel = 2'd0; #1;
    chk("R7 base bank0", info_base, 64'(21'h100005) << 30);
    info_sel = 2'd1; #1;
    chk("R7 base bank1", info_base, 64'h10 << 30);
    chk("R8 size bank1", info_size, 64'd4 << 30);
    chk("R6 ilv bank1", 64'(info_ilv), 64'd1);
    info_sel = 2'd2; #1;
    chk("R8 size bank2", info_size, (64'd1 << 30) / 4);
    chk("R6 ilv bank2", 64'(info_ilv), 64'd4);
    info_sel = 2'd3; #1;
    chk("R8 size full key", info_size, 64'd1024 << 30);
    wr_bank(2'd3, cfg_word(1'b0, 12'hC01, 21'h0, 4'hF, 4'h0));
    #1; chk("R8 upper key bits excluded", info_size, 64'd2 << 30);
    wr_bank(2'd3, cfg_word(1'b0, 12'h00F, 21'h0, 4'h0, 4'h0));
    #1; chk("R6 ilv 16", 64'(info_ilv), 64'd16);
    chk("R8 size over 16", info_size, (64'd16 << 30) / 16);
    wr_bank(2'd3, cfg_word(1'b0, 12'h00F, 21'h0, 4'h8, 4'h0));
    #1; chk("R6 ilv 8", 64'(info_ilv), 64'd8);
    wr_bank(2'd3, cfg_word(1'b0, 12'h00F, 21'h0, 4'hE, 4'h0));
    #1; chk("R6 ilv 2", 64'(info_ilv), 64'd2);
    wr_bank(2'd3, cfg_word(1'b0, 12'h00F, 21'h0, 4'h5, 4'h0));
    #1; chk("R6 other code gives 1", 64'(info_ilv), 64'd1);
    wr_bank(2'd3, cfg_word(1'b0, 12'h00F, 21'h0, 4'h0, 4'h0));
    #1; chk("R9 port id unaffected", 64'(info_valid), 64'd0);
  endtask

  task automatic t_backpressure;
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = mk_addr(12'h013, 4'h0);
    @(negedge clk);
    req_addr = mk_addr(12'h005, 4'h0);
    chk("R11 ready low while held", 64'(req_ready), 64'd0);
    @(negedge clk);
    expect_rsp("R11 first result held", 1'b1, 2'd1, 5'd1, 6'd9);
    chk("R11 still stalled", 64'(req_ready), 64'd0);
    rsp_ready = 1'b1;
    #1; chk("R11 ready follows consumer", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp("R11 second result after release", 1'b1, 2'd0, 5'd1, 6'd8);
    @(negedge clk);
    chk("R10 valid drops when taken", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = 2'd3;
    cfg_wr_data = cfg_word(1'b1, 12'hFFF, 21'h0, 4'hF, 4'h0);
    req_valid = 1'b1; req_addr = mk_addr(12'h7FF, 4'h0);
    @(negedge clk);
    cfg_wr_en = 1'b0; req_valid = 1'b0;
    expect_rsp("R12 lookup sees old contents", 1'b0, 2'd0, 5'd0, 6'd0);
    lookup(mk_addr(12'h7FF, 4'h0));
    expect_rsp("R12 write visible next lookup", 1'b1, 2'd3, 5'd1, 6'd11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_upper();
    t_lower();
    t_priority();
    t_invalid();
    t_info();
    t_backpressure();
    t_same_cycle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule